// File: doc/BRIEF.md
# PCI Initiator Response Watchdog

This block protects bus cycles that the local device launches as a PCI initiator. While a master transaction is open and the addressed target has not yet completed a data phase, the block counts PCI clocks. If the count reaches the programmed limit before a data phase completes, it issues a one-clock master-abort request to the master sequencer, so that a target that never responds cannot stall the bus forever. It also issues a system-error pulse when error reporting is enabled.

The limit comes from an 8-bit configuration register. Only the low nibble sets the timeout, and it is scaled by 16 clocks. A low nibble of zero switches the watchdog off. Every completed data phase, where TRDY# and IRDY# are both sampled low, starts the count again. After an expiry the block stays quiet until the master transaction ends and a new one begins.

Top module: `pci_mst_watchdog`

## Requirements
- R1: After reset the register reads 00h and mabort_o and serr_o are low.
- R2: A clock edge with cfg_we_i high stores all 8 bits of cfg_wdata_i, and cfg_rdata_o shows the stored value from the next cycle on, including bits [7:4].
- R3: While register bits [3:0] are 0 (for example 00h or A0h), mabort_o never rises, however long the target waits.
- R4: A waiting edge is one with mst_active_i high, the watchdog not yet expired in this transaction, and TRDY#/IRDY# not both low. With N = register bits [3:0] nonzero, mabort_o is high in the cycle after the (16*N)-th waiting edge counted since the last restart.
- R5: An edge with mst_active_i high and trdy_ni and irdy_ni both low restarts the count at zero.
- R6: mabort_o is high for exactly one cycle, and there is no further pulse until mst_active_i has been low for at least one edge.
- R7: serr_o pulses in the same cycle as mabort_o when serr_en_i was high at the expiry edge. Otherwise it stays low.
- R8: An edge with mst_active_i low clears the count and re-arms the watchdog.
- R9: Register bits [7:4] have no effect on the timeout length. For example, F2h and 02h both expire after 32 waiting edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | PCI clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Configuration write strobe for the timer register |
| cfg_wdata_i | input | 8 | Configuration write data |
| cfg_rdata_o | output | 8 | Current timer register value |
| mst_active_i | input | 1 | High while the device owns an open initiator transaction |
| trdy_ni | input | 1 | Target ready, active low |
| irdy_ni | input | 1 | Initiator ready, active low |
| serr_en_i | input | 1 | System-error reporting enable |
| mabort_o | output | 1 | One-clock request to end the cycle with a master abort |
| serr_o | output | 1 | One-clock system-error pulse, active high |

## Verification
The counting path is driven in several ways. A target that never answers is tested at the smallest and largest limits, which pins the exact latency. A target that completes data phases at intervals shorter than the limit shows that the count restarts. A transaction that is dropped part-way and then restarted shows that the count clears between transactions. The disabled case is run with register values whose low nibble is zero but whose upper bits differ, and the same low nibble is run with different upper bits to show that those bits do not change the latency. The error-reporting enable is toggled between expiries, so that an abort without SERR can be told apart from one with it.

// File: rtl/pci_wdt_pkg.sv
package pci_wdt_pkg;
  parameter int unsigned WDT_REG_W = 8;
  parameter int unsigned WDT_NIB_W = 4;
  parameter int unsigned WDT_CNT_W = 8;
endpackage

// File: rtl/pci_wdt_cfg_reg.sv
module pci_wdt_cfg_reg #(
  parameter int unsigned REG_W = pci_wdt_pkg::WDT_REG_W,
  parameter int unsigned NIB_W = pci_wdt_pkg::WDT_NIB_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [REG_W-1:0] wdata_i,
  output logic [REG_W-1:0] rdata_o,
  output logic [NIB_W-1:0] nib_o
);
  logic [REG_W-1:0] reg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   reg_q <= '0;
    else if (we_i) reg_q <= wdata_i;
  end

  assign rdata_o = reg_q;
  assign nib_o   = reg_q[NIB_W-1:0];

  p_cfg_load_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> rdata_o == $past(wdata_i));
endmodule

// File: rtl/pci_wdt_counter.sv
module pci_wdt_counter #(
  parameter int unsigned NIB_W = pci_wdt_pkg::WDT_NIB_W,
  parameter int unsigned CNT_W = pci_wdt_pkg::WDT_CNT_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [NIB_W-1:0] nib_i,
  input  logic             mst_active_i,
  input  logic             xfer_i,
  output logic             expire_o
);
  localparam int unsigned LOW_W = CNT_W - NIB_W;

  logic [CNT_W-1:0] limit;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W:0]   cnt_inc;
  logic             done_q;
  logic             en;
  logic             waiting;

  // nibble lands in the top bits, low bits fixed at zero
  generate
    if (LOW_W > 0) begin : g_scaled
      assign limit = {nib_i, {LOW_W{1'b0}}};
    end else begin : g_direct
      assign limit = nib_i[CNT_W-1:0];
    end
  endgenerate

  assign en       = |nib_i;
  assign cnt_inc  = {1'b0, cnt_q} + 1'b1;
  assign waiting  = mst_active_i && !done_q && en && !xfer_i;
  assign expire_o = waiting && (cnt_inc >= {1'b0, limit});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else if (!mst_active_i) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else if (done_q) begin
      cnt_q  <= '0;
    end else if (!en || xfer_i) begin
      cnt_q  <= '0;
    end else if (expire_o) begin
      cnt_q  <= '0;
      done_q <= 1'b1;
    end else begin
      cnt_q  <= cnt_inc[CNT_W-1:0];
    end
  end

  p_xfer_restart_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mst_active_i && xfer_i) |=> cnt_q == '0);
  p_idle_clear_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mst_active_i |=> (cnt_q == '0 && !done_q));
  p_quiet_after_expiry_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> !expire_o);
endmodule

// File: rtl/pci_wdt_event.sv
module pci_wdt_event (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic expire_i,
  input  logic serr_en_i,
  output logic mabort_o,
  output logic serr_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mabort_o <= 1'b0;
      serr_o   <= 1'b0;
    end else begin
      mabort_o <= expire_i;
      serr_o   <= expire_i && serr_en_i;
    end
  end

  p_serr_with_abort_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    serr_o |-> mabort_o);
  p_abort_single_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mabort_o |=> !mabort_o);
endmodule

// File: rtl/pci_mst_watchdog.sv
module pci_mst_watchdog
  import pci_wdt_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 cfg_we_i,
  input  logic [WDT_REG_W-1:0] cfg_wdata_i,
  output logic [WDT_REG_W-1:0] cfg_rdata_o,
  input  logic                 mst_active_i,
  input  logic                 trdy_ni,
  input  logic                 irdy_ni,
  input  logic                 serr_en_i,
  output logic                 mabort_o,
  output logic                 serr_o
);
  logic [WDT_NIB_W-1:0] nib;
  logic                 xfer;
  logic                 expire;

  assign xfer = !trdy_ni && !irdy_ni;

  pci_wdt_cfg_reg #(.REG_W(WDT_REG_W), .NIB_W(WDT_NIB_W)) u_cfg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (cfg_we_i),
    .wdata_i (cfg_wdata_i),
    .rdata_o (cfg_rdata_o),
    .nib_o   (nib)
  );

  pci_wdt_counter #(.NIB_W(WDT_NIB_W), .CNT_W(WDT_CNT_W)) u_cnt (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .nib_i        (nib),
    .mst_active_i (mst_active_i),
    .xfer_i       (xfer),
    .expire_o     (expire)
  );

  pci_wdt_event u_evt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .expire_i  (expire),
    .serr_en_i (serr_en_i),
    .mabort_o  (mabort_o),
    .serr_o    (serr_o)
  );

  p_disabled_quiet_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mabort_o |-> ($past(cfg_rdata_o[WDT_NIB_W-1:0]) != '0));
  p_abort_needs_master_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mabort_o |-> $past(mst_active_i));
endmodule

// File: tb/pci_mst_watchdog_tb.sv
module pci_mst_watchdog_tb_top;
  localparam time CLK_PERIOD = 10ns;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_we = 1'b0;
  logic [7:0] cfg_wdata = '0;
  logic [7:0] cfg_rdata;
  logic       mst = 1'b0;
  logic       trdy_n = 1'b1;
  logic       irdy_n = 1'b1;
  logic       serr_en = 1'b0;
  logic       mabort, serr;

  int checks = 0;
  int fails  = 0;
  string cur_tag = "R1";

  always #(CLK_PERIOD/2) clk = ~clk;

  pci_mst_watchdog dut_i (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(cfg_we), .cfg_wdata_i(cfg_wdata),
    .cfg_rdata_o(cfg_rdata), .mst_active_i(mst), .trdy_ni(trdy_n),
    .irdy_ni(irdy_n), .serr_en_i(serr_en), .mabort_o(mabort), .serr_o(serr)
  );

  // behavioural reference model
  int  m_wait = 0;
  bit  m_done = 0;
  bit  exp_abort = 0, exp_serr = 0;
  int  m_reg = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_wait = 0; m_done = 0; exp_abort = 0; exp_serr = 0; m_reg = 0;
    end else begin
      int lim;
      lim = (m_reg % 16) * 16;
      exp_abort = 0; exp_serr = 0;
      if (!mst) begin
        m_wait = 0; m_done = 0;
      end else if (m_done) begin
        m_wait = 0;
      end else if (lim == 0) begin
        m_wait = 0;
      end else if (!trdy_n && !irdy_n) begin
        m_wait = 0;
      end else begin
        m_wait++;
        if (m_wait >= lim) begin
          exp_abort = 1; exp_serr = serr_en; m_done = 1; m_wait = 0;
        end
      end
      if (cfg_we) m_reg = cfg_wdata;
    end
  end

  task automatic check(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    check(cur_tag, "mabort_o", mabort, exp_abort);
    check(exp_serr || serr ? "R7" : cur_tag, "serr_o", serr, exp_serr);
    check("R2", "cfg_rdata_o", cfg_rdata, m_reg);
  end

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(logic [7:0] v);
    @(negedge clk); cfg_we = 1; cfg_wdata = v;
    @(negedge clk); cfg_we = 0;
  endtask

  task automatic latency(logic [7:0] v, int exp, string tag);
    int n;
    mst = 0; wr(v); idle(1);
    mst = 1; n = 0;
    for (int i = 0; i < 300; i++) begin
      @(negedge clk); n++;
      if (mabort) break;
    end
    check(tag, "abort latency", n, exp);
    idle(20);
    mst = 0; idle(2);
  endtask

  initial begin
    int cyc = 0;
    forever begin
      @(posedge clk); cyc++;
      if (cyc > 100000) begin
        fails++; checks++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
      end
    end
  end

  initial begin
    #(3*CLK_PERIOD); rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check("R1", "reset reg", cfg_rdata, 0);
    check("R1", "reset abort", mabort, 0);
    check("R1", "reset serr", serr, 0);

    // R3 disabled with 00h and A0h
    cur_tag = "R3"; serr_en = 1;
    mst = 1; idle(300); mst = 0; idle(2);
    wr(8'hA0);
    check("R2", "upper nibble readback", cfg_rdata, 8'hA0);
    mst = 1; idle(300); mst = 0; idle(2);

    // R4 R6 R7 smallest limit with SERR enabled
    cur_tag = "R4";
    latency(8'h01, 16, "R4");
    cur_tag = "R6";
    latency(8'h01, 16, "R6");

    // R9 upper bits ignored
    cur_tag = "R9";
    latency(8'hF2, 32, "R9");
    latency(8'h02, 32, "R9");

    // R7 reporting disabled
    cur_tag = "R7"; serr_en = 0;
    latency(8'h03, 48, "R7");
    serr_en = 1;

    // R5 data phases every 20 clocks with limit 32
    cur_tag = "R5";
    wr(8'h02); mst = 1;
    for (int k = 0; k < 10; k++) begin
      idle(20);
      trdy_n = 0; irdy_n = 0; idle(1);
      trdy_n = 1; irdy_n = 1;
    end
    check("R5", "no abort with data phases", mabort, 0);
    // only TRDY# low is not a transfer: expiry still comes
    trdy_n = 0; idle(40); trdy_n = 1;
    mst = 0; idle(2);

    // R8 drop mid-count, then full limit again
    cur_tag = "R8";
    mst = 1; idle(25); mst = 0; idle(1);
    latency(8'h02, 32, "R8");

    // R4 largest limit
    cur_tag = "R4";
    latency(8'h0F, 240, "R4");

    idle(5);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule